// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds four general registers, each 32 bits wide, for a small execution core. Every register can be seen through four overlapping windows: the whole 32-bit word, the low 16-bit half, the upper byte of that half (bits 15:8), and the lower byte (bits 7:0). Two read ports and one write port each carry a register index and a 2-bit size code. A read returns the chosen window, zero-extended to 32 bits. A narrow write merges into the stored word and leaves every bit outside the chosen window as it was.

A separate wide-result path stores a 64-bit value across a fixed pair of registers in one clock, as a multiplier result would need. The upper half goes to register 3, the data register. The lower half goes to register 0, the accumulator. Reads are taken straight from the stored state, so a write becomes visible only after the clock edge that captures it. Copying one register to another is done by feeding a read port's output back into the write port.

Top module: `gpr_alias_file`

## Requirements
- R1: After reset, all four registers (index 0 accumulator, 1 base, 2 count, 3 data) read as zero.
- R2: A read with size code 2'b11 returns all 32 bits of the indexed register.
- R3: A read with size code 2'b10 returns register bits 15:0 in result bits 15:0, with result bits 31:16 zero.
- R4: A read with size code 2'b01 returns register bits 15:8 in result bits 7:0, with result bits 31:8 zero.
- R5: A read with size code 2'b00 returns register bits 7:0 in result bits 7:0, with result bits 31:8 zero.
- R6: A write with size code 2'b00 loads write-data bits 7:0 into register bits 7:0 and leaves bits 31:8 unchanged.
- R7: A write with size code 2'b01 loads write-data bits 7:0 into register bits 15:8 and leaves bits 31:16 and 7:0 unchanged.
- R8: A write with size code 2'b10 loads write-data bits 15:0 into register bits 15:0 and leaves bits 31:16 unchanged.
- R9: A write with size code 2'b11 replaces the whole register with the write data, so a value read from one register and written to another is copied exactly (0x0148 moved from the accumulator reads back as 0x0148 in the base register).
- R10: A wide write stores wide-data bits 63:32 in register 3 and bits 31:0 in register 0 at one clock edge.
- R11: When the wide write and a port write happen in the same cycle, the wide value wins for registers 0 and 3. A port write to register 1 or 2 still takes effect.
- R12: A read in the same cycle as a write to the same register returns the value from before the write. The new value appears after the clock edge.
- R13: With neither write enable asserted, no register changes. The two read ports select their index and size independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_idx | input | 2 | Read port 0 register index |
| rd0_sz | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 zero-extended result |
| rd1_idx | input | 2 | Read port 1 register index |
| rd1_sz | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 zero-extended result |
| wr_en | input | 1 | Port write enable |
| wr_idx | input | 2 | Port write register index |
| wr_sz | input | 2 | Port write size code |
| wr_data | input | 32 | Port write data, right-aligned |
| wide_en | input | 1 | Wide pair write enable |
| wide_data | input | 64 | Wide value: upper half to register 3, lower half to register 0 |

## Verification
The bench aims at the merge of each narrow write. A design that cleared or sign-filled the untouched bits would show up on the next full-word read. A high-byte write that took its byte from data bits 15:8, or placed it in bits 7:0, would also be caught. It reads registers in the same cycle they are written; a design with a forwarding path would return the new value too early. It also sets off wide writes together with port writes to every index. A design with the wrong priority would let the port write overwrite the pair, and a design that blocked all writes on a collision would lose the write to register 1 or 2.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Access-size codes shared by the read and write ports.
    typedef enum logic [1:0] {
        SZ_LO8 = 2'b00,
        SZ_HI8 = 2'b01,
        SZ_H16 = 2'b10,
        SZ_W32 = 2'b11
    } gpr_size_e;

    localparam int unsigned GPR_COUNT  = 4;
    localparam int unsigned GPR_WIDTH  = 32;
    localparam int unsigned GPR_HALF_W = 16;

endpackage

// File: rtl/gpr_view_rd.sv
module gpr_view_rd
    import gpr_pkg::*;
#(
    parameter int unsigned REG_W  = GPR_WIDTH,
    parameter int unsigned HALF_W = GPR_HALF_W
) (
    input  logic [REG_W-1:0] word_i,
    input  logic [1:0]       size_i,
    output logic [REG_W-1:0] view_o
);
    localparam int unsigned BYTE_W = HALF_W / 2;

    gpr_size_e size_e;
    assign size_e = gpr_size_e'(size_i);

    // Pick the window and zero-extend it.
    always_comb begin
        view_o = '0;
        unique case (size_e)
            SZ_LO8:  view_o[BYTE_W-1:0] = word_i[BYTE_W-1:0];
            SZ_HI8:  view_o[BYTE_W-1:0] = word_i[HALF_W-1:BYTE_W];
            SZ_H16:  view_o[HALF_W-1:0] = word_i[HALF_W-1:0];
            default: view_o             = word_i;
        endcase
    end

endmodule

// File: rtl/gpr_merge_wr.sv
module gpr_merge_wr
    import gpr_pkg::*;
#(
    parameter int unsigned REG_W  = GPR_WIDTH,
    parameter int unsigned HALF_W = GPR_HALF_W
) (
    input  logic [REG_W-1:0] old_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [1:0]       size_i,
    output logic [REG_W-1:0] merged_o
);
    localparam int unsigned BYTE_W = HALF_W / 2;

    gpr_size_e size_e;
    assign size_e = gpr_size_e'(size_i);

    // Write data is right-aligned; only the selected window is replaced.
    always_comb begin
        merged_o = old_i;
        unique case (size_e)
            SZ_LO8:  merged_o[BYTE_W-1:0]      = wdata_i[BYTE_W-1:0];
            SZ_HI8:  merged_o[HALF_W-1:BYTE_W] = wdata_i[BYTE_W-1:0];
            SZ_H16:  merged_o[HALF_W-1:0]      = wdata_i[HALF_W-1:0];
            default: merged_o                  = wdata_i;
        endcase
    end

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS = GPR_COUNT,
    parameter int unsigned REG_W    = GPR_WIDTH,
    parameter int unsigned HALF_W   = GPR_HALF_W,
    parameter int unsigned ACC_IDX  = 0,
    parameter int unsigned DAT_IDX  = 3,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned WIDE_W  = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_sz,
    output logic [REG_W-1:0]  rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_sz,
    output logic [REG_W-1:0]  rd1_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_sz,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              wide_en,
    input  logic [WIDE_W-1:0] wide_data
);
    localparam int unsigned NUM_RD = 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] regs;
    } state_t;

    state_t state_q, state_d;

    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
    assign regs_q = state_q.regs;

    // ---------------- read ports ----------------
    logic [NUM_RD-1:0][IDX_W-1:0] rd_idx;
    logic [NUM_RD-1:0][1:0]       rd_sz;
    logic [NUM_RD-1:0][REG_W-1:0] rd_view;

    assign rd_idx[0] = rd0_idx;
    assign rd_idx[1] = rd1_idx;
    assign rd_sz[0]  = rd0_sz;
    assign rd_sz[1]  = rd1_sz;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gpr_view_rd #(
            .REG_W  (REG_W),
            .HALF_W (HALF_W)
        ) u_view (
            .word_i (state_q.regs[rd_idx[p]]),
            .size_i (rd_sz[p]),
            .view_o (rd_view[p])
        );
    end

    assign rd0_data = rd_view[0];
    assign rd1_data = rd_view[1];

    // ---------------- write merge ----------------
    logic [REG_W-1:0] wr_merged;

    gpr_merge_wr #(
        .REG_W  (REG_W),
        .HALF_W (HALF_W)
    ) u_merge (
        .old_i    (state_q.regs[wr_idx]),
        .wdata_i  (wr_data),
        .size_i   (wr_sz),
        .merged_o (wr_merged)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.regs[wr_idx] = wr_merged;
        end
        // The wide pair is applied last so it wins on its two registers.
        if (wide_en) begin
            state_d.regs[DAT_IDX] = wide_data[WIDE_W-1:REG_W];
            state_d.regs[ACC_IDX] = wide_data[REG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned REG_W    = 32,
    parameter int unsigned ACC_IDX  = 0,
    parameter int unsigned DAT_IDX  = 3,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned WIDE_W  = 2 * REG_W
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [1:0]                     rd0_sz,
    input logic [REG_W-1:0]               rd0_data,
    input logic [1:0]                     rd1_sz,
    input logic [REG_W-1:0]               rd1_data,
    input logic                           wr_en,
    input logic [IDX_W-1:0]               wr_idx,
    input logic [1:0]                     wr_sz,
    input logic [REG_W-1:0]               wr_data,
    input logic                           wide_en,
    input logic [WIDE_W-1:0]              wide_data,
    input logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);

    // R5
    lo8_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_sz == 2'b00) |-> (rd0_data[REG_W-1:8] == '0));

    // R4
    hi8_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_sz == 2'b01) |-> (rd1_data[REG_W-1:8] == '0));

    // R3
    h16_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_sz == 2'b10) |-> (rd0_data[REG_W-1:16] == '0));

    // R6
    lo8_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide_en && wr_sz == 2'b00) |=>
        (regs_q[$past(wr_idx)][REG_W-1:8] == $past(regs_q[wr_idx][REG_W-1:8])));

    // R7
    hi8_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide_en && wr_sz == 2'b01) |=>
        (regs_q[$past(wr_idx)][15:8] == $past(wr_data[7:0]) &&
         regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0]) &&
         regs_q[$past(wr_idx)][REG_W-1:16] == $past(regs_q[wr_idx][REG_W-1:16])));

    // R8
    h16_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide_en && wr_sz == 2'b10) |=>
        (regs_q[$past(wr_idx)][REG_W-1:16] == $past(regs_q[wr_idx][REG_W-1:16])));

    // R9
    w32_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide_en && wr_sz == 2'b11) |=>
        (regs_q[$past(wr_idx)] == $past(wr_data)));

    // R10
    wide_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wide_en |=> (regs_q[DAT_IDX] == $past(wide_data[WIDE_W-1:REG_W]) &&
                     regs_q[ACC_IDX] == $past(wide_data[REG_W-1:0])));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wide_en) |=> $stable(regs_q));

endmodule

bind gpr_alias_file gpr_alias_file_chk #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .ACC_IDX  (ACC_IDX),
    .DAT_IDX  (DAT_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd0_sz    (rd0_sz),
    .rd0_data  (rd0_data),
    .rd1_sz    (rd1_sz),
    .rd1_data  (rd1_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_sz     (wr_sz),
    .wr_data   (wr_data),
    .wide_en   (wide_en),
    .wide_data (wide_data),
    .regs_q    (regs_q)
);

// File: tb/gpr_alias_file_test.sv
module gpr_alias_file_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rd0_idx = '0, rd0_sz = '0, rd1_idx = '0, rd1_sz = '0;
    logic [31:0] rd0_data, rd1_data;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0, wr_sz = '0;
    logic [31:0] wr_data = '0;
    logic        wide_en = 1'b0;
    logic [63:0] wide_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] mdl [4];

    always #4 clk = ~clk;

    gpr_alias_file uut (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd0_sz(rd0_sz), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_sz(rd1_sz), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sz(wr_sz), .wr_data(wr_data),
        .wide_en(wide_en), .wide_data(wide_data)
    );

    function automatic logic [31:0] ref_view(logic [31:0] w, logic [1:0] s);
        case (s)
            2'b00:   return w & 32'h0000_00FF;
            2'b01:   return (w >> 8) & 32'h0000_00FF;
            2'b10:   return w & 32'h0000_FFFF;
            default: return w;
        endcase
    endfunction

    function automatic string size_tag(logic [1:0] s);
        case (s)
            2'b00:   return "R5";
            2'b01:   return "R4";
            2'b10:   return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One clock: drive, compare reads against the model (pre-edge), update model.
    task automatic step(input logic we, input logic [1:0] wi, input logic [1:0] ws,
                        input logic [31:0] wd, input logic wde, input logic [63:0] wdd,
                        input logic [1:0] r0i, input logic [1:0] r0s,
                        input logic [1:0] r1i, input logic [1:0] r1s, input string extra);
        logic [31:0] m;
        wr_en = we; wr_idx = wi; wr_sz = ws; wr_data = wd;
        wide_en = wde; wide_data = wdd;
        rd0_idx = r0i; rd0_sz = r0s; rd1_idx = r1i; rd1_sz = r1s;
        #1;
        // R12: same-cycle reads see the old contents
        check($sformatf("%s%s rd0", size_tag(r0s), (we && wi == r0i) ? " R12" : extra),
              rd0_data, ref_view(mdl[r0i], r0s));
        check($sformatf("%s%s rd1", size_tag(r1s), (we && wi == r1i) ? " R12" : extra),
              rd1_data, ref_view(mdl[r1i], r1s));
        @(posedge clk);
        if (we) begin
            m = mdl[wi];
            case (ws)
                2'b00:   m = (m & ~32'h0000_00FF) | (wd & 32'h0000_00FF);        // R6
                2'b01:   m = (m & ~32'h0000_FF00) | ((wd & 32'h0000_00FF) << 8); // R7
                2'b10:   m = (m & ~32'h0000_FFFF) | (wd & 32'h0000_FFFF);        // R8
                default: m = wd;                                                 // R9
            endcase
            mdl[wi] = m;
        end
        if (wde) begin // R10, R11
            mdl[3] = wdd[63:32];
            mdl[0] = wdd[31:0];
        end
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] idx, input string tag);
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 64'h0, idx, 2'b11, idx, 2'b11, tag);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] moved;
        for (int i = 0; i < 4; i++) mdl[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all registers zero after reset
        for (int i = 0; i < 4; i++) peek(2'(i), " R1");

        // R9: load accumulator then copy it to base through the ports
        step(1'b1, 2'd0, 2'b11, 32'h0000_0148, 1'b0, 64'h0, 2'd0, 2'b11, 2'd1, 2'b11, " R9");
        rd0_idx = 2'd0; rd0_sz = 2'b11; #1; moved = rd0_data;
        step(1'b1, 2'd1, 2'b11, moved, 1'b0, 64'h0, 2'd0, 2'b11, 2'd1, 2'b11, " R9");
        rd1_idx = 2'd1; rd1_sz = 2'b11; #1;
        check("R9 copy", rd1_data, 32'h0000_0148);

        // R6, R7, R8: narrow merges on a patterned word
        step(1'b1, 2'd2, 2'b11, 32'hAABB_CCDD, 1'b0, 64'h0, 2'd2, 2'b11, 2'd2, 2'b01, "");
        step(1'b1, 2'd2, 2'b00, 32'h1234_5611, 1'b0, 64'h0, 2'd2, 2'b11, 2'd2, 2'b00, " R6");
        peek(2'd2, " R6");
        check("R6 merged", rd0_data, 32'hAABB_CC11);
        step(1'b1, 2'd2, 2'b01, 32'hFFFF_FF22, 1'b0, 64'h0, 2'd2, 2'b01, 2'd2, 2'b10, " R7");
        peek(2'd2, " R7");
        check("R7 merged", rd0_data, 32'hAABB_2211);
        step(1'b1, 2'd2, 2'b10, 32'h9999_3344, 1'b0, 64'h0, 2'd2, 2'b10, 2'd2, 2'b00, " R8");
        peek(2'd2, " R8");
        check("R8 merged", rd0_data, 32'hAABB_3344);

        // R10: wide pair
        step(1'b0, 2'd0, 2'b00, 32'h0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 2'd3, 2'b11, 2'd0, 2'b11, " R10");
        peek(2'd3, " R10"); check("R10 upper", rd0_data, 32'hDEAD_BEEF);
        peek(2'd0, " R10"); check("R10 lower", rd0_data, 32'h0BAD_F00D);

        // R11: collisions with every write index
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 2'(i), 2'b11, 32'h5555_0000 + i, 1'b1, 64'h1111_2222_3333_4444,
                 2'(i), 2'b11, 2'd3, 2'b11, " R11");
            peek(2'(i), " R11");
        end
        peek(2'd1, " R11"); check("R11 base kept", rd0_data, 32'h5555_0001);

        // R13: idle cycles change nothing, ports independent
        for (int i = 0; i < 8; i++)
            step(1'b0, 2'(i), 2'(i), 32'hFFFF_FFFF, 1'b0, 64'h0, 2'(i), 2'(i >> 1), 2'(3 - i), 2'(i), " R13");

        // Pseudo-random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom;
            step(r[0], 2'(r[2:1]), 2'(r[4:3]), $urandom, (r[7:5] == 3'b000),
                 {$urandom, $urandom}, 2'(r[9:8]), 2'(r[11:10]), 2'(r[13:12]), 2'(r[15:14]), "");
        end

        report();
    end

endmodule